// File: doc/BRIEF.md
# Periodic Process Timeout Scanner

The block runs once for each interrupt on the timer channel. It keeps two words in shared memory: a sub-tick counter and the current time. Each interrupt adds one to the sub-tick counter. When the new value is still negative, the block writes it back and stops. When the new value reaches zero or above, the block reloads the counter with minus three and adds one to the current time. The current time therefore advances once every third interrupt.

After the time advances, the block reads a first-block and a last-block pointer from memory. It then visits each five-word process control block from the first pointer onward. A block has timed out when its timeout word is non-zero and equal to the current time. For each timed-out block, the block asks an external engine to move that process to the ready queue. The request gives no source queue. The block holds the request until the engine answers. It then clears the waiting-on-condition flag of that process and reads the current time again before it goes on.

A separate combinational helper turns a tick count into an absolute deadline. Software uses this value when it puts a process to sleep.

Top module: `timeout_scanner`

## Requirements
- R1: Each accepted `tick` writes the sub-tick word (address timer+1) incremented by one. If the result has bit 15 set, no scan takes place, the current time is unchanged and no requeue request is made.
- R2: When the incremented sub-tick value has bit 15 clear, the block writes 16'hFFFD (minus three) to the sub-tick word and writes the current-time word (timer address 16'o344) plus one.
- R3: A block whose timeout word (block offset 2) is non-zero and equal to the current time raises `rq_req`, with `rq_proc` equal to the block's base address.
- R4: A timeout word of 0 never causes a requeue, even when the current time is 0.
- R5: For a timed-out block, bit 3 (value 8) of the flags word (block offset 3) is cleared and every other flag bit is kept. Flags of blocks that do not time out are left unchanged.
- R6: The first-block pointer is read from 16'o1075 and the last-block pointer from 16'o1076. Blocks are visited at a stride of 5 words while the address does not exceed the last pointer. The first block is always visited, even when it lies beyond the last pointer.
- R7: `rq_req` and `rq_proc` stay unchanged until `rq_done` is seen, and the scan does not advance in the meantime.
- R8: After each requeue completes, the current time is read again from memory. Later blocks are compared against the value just read.
- R9: `dl_value` is 0 when `dl_ticks` is 0. Otherwise it is `dl_now + dl_ticks` modulo 2^16, and a sum of 0 is replaced by 1.
- R10: A `tick` that arrives while `busy` is high is ignored.
- R11: `done` is high for exactly one cycle when a skipped or completed scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-channel interrupt pulse |
| mem_addr | output | 16 | Word address of the memory access |
| mem_we | output | 1 | Write strobe, taken at the clock edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data for `mem_addr`, same cycle |
| rq_req | output | 1 | Requeue request to the ready queue, source unknown |
| rq_proc | output | 16 | Base address of the block to requeue |
| rq_done | input | 1 | Requeue engine completion |
| dl_now | input | 16 | Current time for the deadline helper |
| dl_ticks | input | 16 | Tick count for the deadline helper |
| dl_value | output | 16 | Computed deadline |
| busy | output | 1 | Block is processing a tick |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench drives the sub-tick counter from a value that stays negative and from one that reaches zero. This shows the difference between a skipped run and a scanning run. Scan patterns cover the following cases:
- matching, non-matching and zero timeouts, including a time wrap to 0;
- a first pointer beyond the last pointer;
- a time word changed while a requeue is pending, which shows whether the time is read again afterwards.

The deadline helper is swept over zero ticks, plain sums and sums that wrap to 0.

// File: rtl/timeout_scanner.sv
module timeout_scanner #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] TIMER_ADDR = 16'o344,
  parameter logic [AW-1:0] FIRST_PTR_ADDR = 16'o1075,
  parameter logic [AW-1:0] LAST_PTR_ADDR = 16'o1076,
  parameter int BLK_WORDS = 5,
  parameter int TMO_OFS = 2,
  parameter int FLG_OFS = 3,
  parameter int WAIT_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rq_req,
  output logic [AW-1:0] rq_proc,
  input  logic          rq_done,
  input  logic [DW-1:0] dl_now,
  input  logic [DW-1:0] dl_ticks,
  output logic [DW-1:0] dl_value,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] SUB_ADDR = TIMER_ADDR + AW'(1);
  localparam logic [DW-1:0] RELOAD   = {DW{1'b1}} - DW'(2);
  localparam logic [DW-1:0] WAIT_MSK = DW'(1) << WAIT_BIT;

  typedef enum logic [2:0] {S_IDLE, S_SUB, S_TIME, S_FIRST, S_LAST, S_CHK, S_RQ, S_FLAG} st_t;
  st_t st;
  logic [AW-1:0] ptr, last;
  logic [DW-1:0] now;
  logic          retime;

  logic [DW-1:0] sub_inc, dl_sum;
  logic [AW-1:0] nxt;
  logic          hit, more;

  assign sub_inc = mem_rdata + DW'(1);
  assign nxt     = ptr + AW'(BLK_WORDS);
  assign more    = nxt <= last;
  assign hit     = (mem_rdata != '0) && (mem_rdata == now);
  assign busy    = st != S_IDLE;
  assign rq_req  = st == S_RQ;
  assign rq_proc = ptr;

  assign dl_sum   = dl_now + dl_ticks;
  assign dl_value = (dl_ticks == '0) ? '0 : ((dl_sum == '0) ? DW'(1) : dl_sum);

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (st)
      S_SUB:   begin mem_addr = SUB_ADDR; mem_we = 1'b1;
                     mem_wdata = sub_inc[DW-1] ? sub_inc : RELOAD; end
      S_TIME:  begin mem_addr = TIMER_ADDR; mem_we = 1'b1; mem_wdata = sub_inc; end
      S_FIRST: mem_addr = FIRST_PTR_ADDR;
      S_LAST:  mem_addr = LAST_PTR_ADDR;
      S_CHK:   mem_addr = retime ? TIMER_ADDR : ptr + AW'(TMO_OFS);
      S_FLAG:  begin mem_addr = ptr + AW'(FLG_OFS); mem_we = 1'b1;
                     mem_wdata = mem_rdata & ~WAIT_MSK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; last <= '0; now <= '0; retime <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE:  if (tick) st <= S_SUB;
        S_SUB:   if (sub_inc[DW-1]) begin st <= S_IDLE; done <= 1'b1; end
                 else st <= S_TIME;
        S_TIME:  begin now <= sub_inc; st <= S_FIRST; end
        S_FIRST: begin ptr <= mem_rdata; st <= S_LAST; end
        S_LAST:  begin last <= mem_rdata; retime <= 1'b0; st <= S_CHK; end
        S_CHK: begin
          if (retime) now <= mem_rdata;
          if (!retime && hit) st <= S_RQ;
          else begin
            retime <= 1'b0;
            if (more) ptr <= nxt;
            else begin st <= S_IDLE; done <= 1'b1; end
          end
        end
        S_RQ:    if (rq_done) st <= S_FLAG;
        S_FLAG:  begin retime <= 1'b1; st <= S_CHK; end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rq_req && !rq_done |=> rq_req && $stable(rq_proc));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_deadline_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    dl_ticks != '0 |-> dl_value != '0);
  a_r2_sub_negative: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr == SUB_ADDR |-> mem_wdata[DW-1]);
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/timeout_scanner_tb.sv
module timeout_scanner_tb;
  localparam logic [15:0] TA = 16'o344;
  localparam logic [15:0] FA = 16'o1075;
  localparam logic [15:0] LA = 16'o1076;

  logic clk = 0, rst_n = 0, tick = 0, rq_done = 0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, rq_proc, dl_now = 0, dl_ticks = 0, dl_value;
  logic mem_we, rq_req, busy, done;
  logic [15:0] mem [0:1023];
  logic poke_en = 0, poke_arm = 0;
  logic [15:0] poke_val = 0;
  logic [15:0] rq_log [0:7];
  int rq_n = 0, wait_cnt = 0, n_chk = 0, n_fail = 0, done_cycles = 0;

  always #10 clk = ~clk;

  timeout_scanner u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rq_req(rq_req),
    .rq_proc(rq_proc), .rq_done(rq_done), .dl_now(dl_now), .dl_ticks(dl_ticks),
    .dl_value(dl_value), .busy(busy), .done(done));

  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    else if (poke_en) mem[TA[9:0]] <= poke_val;
  end

  always @(negedge clk) begin
    rq_done <= 1'b0;
    poke_en <= 1'b0;
    if (done) done_cycles <= done_cycles + 1;
    if (rq_req && !rq_done) begin
      if (wait_cnt == 3) begin
        wait_cnt <= 0;
        rq_done <= 1'b1;
        if (rq_n < 8) rq_log[rq_n] <= rq_proc;
        rq_n <= rq_n + 1;
        if (poke_arm) begin poke_en <= 1'b1; poke_arm <= 1'b0; end
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_tick(input bit extra_tick);
    @(negedge clk); tick = 1; done_cycles = 0;
    @(negedge clk); tick = 0;
    if (extra_tick) begin
      repeat (2) @(negedge clk);
      tick = 1; @(negedge clk); tick = 0;
    end
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic blk(input logic [15:0] b, input logic [15:0] tmo, input logic [15:0] flg);
    mem[b[9:0]] = 16'h0; mem[b[9:0]+1] = 16'h0;
    mem[b[9:0]+2] = tmo; mem[b[9:0]+3] = flg; mem[b[9:0]+4] = 16'h0;
  endtask

  localparam int NV = 7;
  localparam logic [47:0] DLV [NV] = '{
    {16'd100, 16'd0, 16'd0}, {16'd100, 16'd5, 16'd105}, {16'hFFFF, 16'd1, 16'd1},
    {16'hFFFE, 16'd1, 16'hFFFF}, {16'hFFF0, 16'h0010, 16'd1}, {16'd0, 16'd0, 16'd0},
    {16'd7, 16'hFFF9, 16'd1}};

  initial begin
    #(20 * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset busy", {15'd0, busy}, 16'd0);
    check("reset rq_req", {15'd0, rq_req}, 16'd0);
    check("reset done", {15'd0, done}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      dl_now = DLV[i][47:32]; dl_ticks = DLV[i][31:16];
      #1;
      check("R9 deadline", dl_value, DLV[i][15:0]);
    end

    // R1: skip, sub stays negative
    mem[TA[9:0]] = 16'd50; mem[TA[9:0]+1] = 16'hFFFD;
    run_tick(0);
    check("R1 sub incremented", mem[TA[9:0]+1], 16'hFFFE);
    check("R1 time unchanged", mem[TA[9:0]], 16'd50);
    check("R1 no requeue", 16'(rq_n), 16'd0);
    check("R11 done one cycle", 16'(done_cycles), 16'd1);

    // R2 R3 R5 R6 R10: full scan
    mem[TA[9:0]] = 16'd99; mem[TA[9:0]+1] = 16'hFFFF;
    mem[FA[9:0]] = 16'h100; mem[LA[9:0]] = 16'h10F;
    blk(16'h100, 16'd100, 16'h000F);
    blk(16'h105, 16'd0, 16'h0008);
    blk(16'h10A, 16'd55, 16'h000C);
    blk(16'h10F, 16'd100, 16'h0288);
    blk(16'h114, 16'd100, 16'h0008);
    rq_n = 0;
    run_tick(1);
    check("R2 sub reload", mem[TA[9:0]+1], 16'hFFFD);
    check("R2 time advanced", mem[TA[9:0]], 16'd100);
    check("R3 requeue count", 16'(rq_n), 16'd2);
    check("R3 first requeued", rq_log[0], 16'h100);
    check("R6 last requeued", rq_log[1], 16'h10F);
    check("R5 flag cleared", mem[16'h103], 16'h0007);
    check("R5 other flags kept", mem[16'h112], 16'h0280);
    check("R5 untouched flags", mem[16'h10D], 16'h000C);
    check("R6 beyond last untouched", mem[16'h117], 16'h0008);
    check("R11 done one cycle scan", 16'(done_cycles), 16'd1);

    // R8: time changed during requeue
    mem[TA[9:0]] = 16'd199; mem[TA[9:0]+1] = 16'hFFFF;
    mem[FA[9:0]] = 16'h100; mem[LA[9:0]] = 16'h105;
    blk(16'h100, 16'd200, 16'h0008);
    blk(16'h105, 16'd201, 16'h0008);
    rq_n = 0; poke_val = 16'd201; poke_arm = 1;
    run_tick(0);
    check("R8 retimed match count", 16'(rq_n), 16'd2);
    check("R8 second block", rq_log[1], 16'h105);

    // R4: time wraps to 0, timeout 0 ignored
    mem[TA[9:0]] = 16'hFFFF; mem[TA[9:0]+1] = 16'hFFFF;
    mem[FA[9:0]] = 16'h100; mem[LA[9:0]] = 16'h105;
    blk(16'h100, 16'd0, 16'h0008);
    blk(16'h105, 16'd1, 16'h0008);
    rq_n = 0;
    run_tick(0);
    check("R4 time wrapped", mem[TA[9:0]], 16'd0);
    check("R4 zero timeout no requeue", 16'(rq_n), 16'd0);
    check("R4 flags kept", mem[16'h103], 16'h0008);

    // R6: first beyond last still visited once
    mem[TA[9:0]] = 16'd5; mem[TA[9:0]+1] = 16'hFFFF;
    mem[FA[9:0]] = 16'h200; mem[LA[9:0]] = 16'h100;
    blk(16'h200, 16'd6, 16'h0008);
    blk(16'h205, 16'd6, 16'h0008);
    rq_n = 0;
    run_tick(0);
    check("R6 single visit count", 16'(rq_n), 16'd1);
    check("R6 single visit block", rq_log[0], 16'h200);
    check("R6 next untouched", mem[16'h208], 16'h0008);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule